// File: doc/BRIEF.md
# Deferred Refresh Request Accumulator

This block produces the periodic auto-refresh demand for a dynamic-memory command scheduler. A programmable interval counter raises one refresh event every N clock cycles. Each event is added to a small backlog counter instead of being forced onto the command bus. The block asks the scheduler for a refresh whenever the backlog is non-zero and user traffic is not holding the command path. Each acknowledged request retires one backlog entry, so a backlog built up during a long user burst drains as a run of consecutive refresh commands once the path is free.

The backlog holds at most 15 entries. When it is full, the block raises an urgent flag and requests a refresh even while user traffic is active, so the scheduler can put the refresh ahead of user accesses. The interval register takes a default value at reset and can be rewritten at any time. A rewrite restarts the interval count and leaves the backlog unchanged.

Top module: `rfsh_backlog`

## Requirements
- R1: While reset is held and directly after it, the backlog count is 0, and `rfshReq` and `rfshUrgent` are low. The interval register holds the parameter `DEF_INTERVAL`.
- R2: With interval value N and no rewrite, the backlog gains one entry on every N-th rising edge. The first of these is the N-th edge after reset is released.
- R3: `rfshReq` is high exactly when the backlog is non-zero and either `userBusy` is low or the backlog is full.
- R4: An edge with both `rfshAck` and `rfshReq` high removes one backlog entry. `rfshAck` while `rfshReq` is low has no effect on the backlog.
- R5: With `userBusy` low and `rfshAck` returned on every cycle, the backlog falls by one per cycle. `rfshReq` stays high until the backlog reaches 0.
- R6: On an edge where an interval event and an accepted acknowledge coincide, the backlog count is unchanged.
- R7: The backlog saturates at 15. An interval event at 15 with no accepted acknowledge is dropped, and the count stays 15.
- R8: `rfshUrgent` is high exactly when the backlog is 15. While it is high, `rfshReq` is high regardless of `userBusy`.
- R9: An edge with `intervalWe` high loads `intervalData` and restarts the interval count. That edge produces no interval event. The next event falls on the N'-th edge after it, where N' is the new value. The backlog is not changed by the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| intervalWe | input | 1 | Load strobe for the refresh interval |
| intervalData | input | INTERVAL_W | New interval value in cycles; must be non-zero |
| userBusy | input | 1 | Command path held by user traffic |
| rfshAck | input | 1 | Scheduler accepts the refresh request this cycle |
| rfshReq | output | 1 | Refresh request to the scheduler |
| rfshUrgent | output | 1 | Backlog full; refresh must precede user traffic |
| pendCnt | output | PEND_W | Current backlog count |

## Verification
`rfshReq` and `rfshUrgent` are combinational in the registered backlog and `userBusy`. They are therefore valid in the same cycle an input changes and are checked 1 ns after the edge that settled the backlog. A backlog change caused by an interval event, an acknowledge or a write shows on `pendCnt` one edge later. Every check is taken 1 ns after the edge that registered the change. The bench counts edges from reset release, so interval events fall at known edges: multiples of 6 under the default used, or multiples of 3 after the rewrite edge. Expected counts are derived from those edge numbers.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef struct packed {
    logic inc;     // add one backlog entry
    logic dec;     // retire one backlog entry
    logic reload;  // load new interval, restart count
  } rfshStrobe_t;
endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int INTERVAL_W   = 12,
  parameter int DEF_INTERVAL = 780,
  parameter int PEND_W       = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rfshStrobe_t           stb,
  input  logic [INTERVAL_W-1:0] intervalData,
  output logic                  tick,
  output logic                  pendZero,
  output logic                  pendFull,
  output logic [PEND_W-1:0]     pendCnt
);
  localparam logic [PEND_W-1:0]     PEND_MAX = '1;
  localparam logic [PEND_W-1:0]     PEND_ONE = PEND_W'(1);
  localparam logic [INTERVAL_W-1:0] DEF_VAL  = INTERVAL_W'(DEF_INTERVAL);

  logic [INTERVAL_W-1:0] intervalReg;
  logic [INTERVAL_W-1:0] cnt;
  logic [INTERVAL_W:0]   cntNext;
  logic [PEND_W-1:0]     pend;

  assign cntNext  = {1'b0, cnt} + (INTERVAL_W + 1)'(1);
  assign tick     = (cntNext >= {1'b0, intervalReg});
  assign pendZero = (pend == '0);
  assign pendFull = (pend == PEND_MAX);
  assign pendCnt  = pend;

  // interval register and cycle counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalReg <= DEF_VAL;
      cnt         <= '0;
    end else if (stb.reload) begin
      intervalReg <= intervalData;
      cnt         <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cntNext[INTERVAL_W-1:0];
    end
  end

  // backlog counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
    end else begin
      unique case ({stb.inc, stb.dec})
        2'b10:   pend <= pend + PEND_ONE;
        2'b01:   pend <= pend - PEND_ONE;
        default: pend <= pend;
      endcase
    end
  end

  // R2: the count never passes the interval
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (intervalReg != '0) |-> (cnt < intervalReg));

  // R6: coincident event and acknowledge keep the count
  assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc && stb.dec) |=> (pend == $past(pend)));

  // R7: a full backlog never wraps
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pend == PEND_MAX && !stb.dec) |=> (pend == PEND_MAX));
endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        pendZero,
  input  logic        pendFull,
  input  logic        userBusy,
  input  logic        rfshAck,
  input  logic        intervalWe,
  output rfshStrobe_t stb,
  output logic        rfshReq,
  output logic        rfshUrgent
);
  logic accept;

  always_comb begin
    rfshUrgent = pendFull;
    rfshReq    = !pendZero && (!userBusy || pendFull);
    accept     = rfshReq && rfshAck;
    stb.reload = intervalWe;
    stb.dec    = accept;
    stb.inc    = tick && !intervalWe && (!pendFull || accept);
  end

  // R4: nothing is retired while no request is raised
  assert_ack_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!rfshReq) |-> (!stb.dec));
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog
  import rfsh_pkg::*;
#(
  parameter int INTERVAL_W   = 12,
  parameter int DEF_INTERVAL = 780,
  parameter int PEND_W       = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  intervalWe,
  input  logic [INTERVAL_W-1:0] intervalData,
  input  logic                  userBusy,
  input  logic                  rfshAck,
  output logic                  rfshReq,
  output logic                  rfshUrgent,
  output logic [PEND_W-1:0]     pendCnt
);
  rfshStrobe_t stb;
  logic        tick;
  logic        pendZero;
  logic        pendFull;

  rfsh_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .pendZero  (pendZero),
    .pendFull  (pendFull),
    .userBusy  (userBusy),
    .rfshAck   (rfshAck),
    .intervalWe(intervalWe),
    .stb       (stb),
    .rfshReq   (rfshReq),
    .rfshUrgent(rfshUrgent)
  );

  rfsh_datapath #(
    .INTERVAL_W  (INTERVAL_W),
    .DEF_INTERVAL(DEF_INTERVAL),
    .PEND_W      (PEND_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .intervalData(intervalData),
    .tick        (tick),
    .pendZero    (pendZero),
    .pendFull    (pendFull),
    .pendCnt     (pendCnt)
  );

  // R3: an empty backlog never requests
  assert_idle_no_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt == '0) |-> !rfshReq);

  // R8: urgency always comes with a request
  assert_urgent_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    rfshUrgent |-> rfshReq);

  // R5: an accepted refresh with more queued leaves work pending
  assert_drain_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rfshReq && rfshAck && pendCnt > PEND_W'(1)) |=> (pendCnt != '0));
endmodule

// File: tb/test_rfsh_backlog.sv
module test_rfsh_backlog;
  localparam int IW  = 8;
  localparam int DEF = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          intervalWe = 1'b0;
  logic [IW-1:0] intervalData = '0;
  logic          userBusy = 1'b1;
  logic          ackEn = 1'b0;
  logic          ackForce = 1'b0;
  logic          rfshAck;
  logic          rfshReq;
  logic          rfshUrgent;
  logic [3:0]    pendCnt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  assign rfshAck = (ackEn & rfshReq) | ackForce;

  always #5 clk = ~clk;

  rfsh_backlog #(.INTERVAL_W(IW), .DEF_INTERVAL(DEF), .PEND_W(4)) i_rfsh_backlog (
    .clk(clk), .rstN(rstN), .intervalWe(intervalWe), .intervalData(intervalData),
    .userBusy(userBusy), .rfshAck(rfshAck), .rfshReq(rfshReq),
    .rfshUrgent(rfshUrgent), .pendCnt(pendCnt)
  );

  // {cycles[15:8], busy[7], ackEn[6], pend[5:2], req[1], urgent[0]}
  localparam logic [15:0] VEC [10] = '{
    {8'd18, 1'b1, 1'b1, 4'd3,  1'b0, 1'b0},  // R2 three events while busy
    {8'd3,  1'b0, 1'b1, 4'd0,  1'b0, 1'b0},  // R5 drain back to back
    {8'd3,  1'b1, 1'b1, 4'd1,  1'b0, 1'b0},  // R3 busy holds request
    {8'd1,  1'b0, 1'b0, 4'd1,  1'b1, 1'b0},  // R3 free path requests
    {8'd83, 1'b1, 1'b0, 4'd15, 1'b1, 1'b1},  // R8 full forces request
    {8'd6,  1'b1, 1'b0, 4'd15, 1'b1, 1'b1},  // R7 saturation
    {8'd1,  1'b1, 1'b1, 4'd14, 1'b0, 1'b0},  // R8 urgent ack while busy
    {8'd5,  1'b1, 1'b1, 4'd15, 1'b1, 1'b1},  // R2 refill to full
    {8'd6,  1'b0, 1'b1, 4'd10, 1'b1, 1'b0},  // R6 event with ack
    {8'd10, 1'b0, 1'b1, 4'd1,  1'b1, 1'b0}   // R5 R6 long drain
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    edges(2);
    check("R1 pend", int'(pendCnt), 0);
    check("R1 req", int'(rfshReq), 0);
    check("R1 urgent", int'(rfshUrgent), 0);
    rstN = 1'b1;
  endtask

  initial begin
    #1;
    userBusy = 1'b1;
    doReset();
    for (int i = 0; i < 10; i++) begin
      userBusy = VEC[i][7];
      ackEn    = VEC[i][6];
      edges(int'(VEC[i][15:8]));
      check($sformatf("vec%0d pend", i), int'(pendCnt), int'(VEC[i][5:2]));
      check($sformatf("vec%0d req", i), int'(rfshReq), int'(VEC[i][1]));
      check($sformatf("vec%0d urgent", i), int'(rfshUrgent), int'(VEC[i][0]));
    end

    // directed: ignored acks and interval rewrite
    userBusy = 1'b1;
    ackEn    = 1'b0;
    doReset();
    ackForce = 1'b1;
    edges(3);                       // edges 1..3
    check("R4 ack at empty", int'(pendCnt), 0);
    ackForce = 1'b0;
    edges(2);                       // edges 4,5
    check("R2 before first event", int'(pendCnt), 0);
    edges(1);                       // edge 6
    check("R2 first event", int'(pendCnt), 1);
    ackForce = 1'b1;
    edges(1);                       // edge 7, busy so no request
    check("R4 ack without req", int'(pendCnt), 1);
    ackForce     = 1'b0;
    intervalWe   = 1'b1;
    intervalData = 8'd3;
    edges(1);                       // edge 8, rewrite
    intervalWe = 1'b0;
    check("R9 write keeps backlog", int'(pendCnt), 1);
    edges(2);                       // edges 9,10
    check("R9 restarted count", int'(pendCnt), 1);
    edges(1);                       // edge 11
    check("R9 new interval event", int'(pendCnt), 2);
    edges(3);                       // edge 14
    check("R9 second new event", int'(pendCnt), 3);
    userBusy = 1'b0;
    #1;
    check("R3 req when free", int'(rfshReq), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule